// File: doc/BRIEF.md
# Multiplexed ADC serial port

This block is the digital serial port of an eight-channel successive-approximation converter. The host frames each transfer by pulling the chip-select/convert line low. During the frame the block reads a seven-bit setup word from the serial input. It also shifts the most recent conversion result out on the serial output, most significant bit first. When the frame ends with the line going high, a complete setup word is decoded. The decode gives the positive and negative input selections, the polarity mode and the sleep request. These values drive the analog multiplexer for the conversion that this same rising edge starts.

The serial lines are treated as signals already synchronous to the system clock `clk`. The block finds their edges itself. It takes a bit on a rising clock-line edge and advances the output on a falling one. The converter core delivers its raw code as an offset-binary word together with a one-cycle done strobe. The port latches that word and formats it according to the polarity mode in force at that moment.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the selection is positive channel 0, negative channel 1, negative not ground, bipolar mode, no sleep, no error, output enable low.
- R2: Setup bits are taken on serial-clock rising edges while the frame is active, first bit into position 6 (bit order: pair/single at bit 6, odd at bit 5, address high at bit 4, address low at bit 3, common at bit 2, unipolar at bit 1, sleep at bit 0). Decoded outputs change only when chip-select rises.
- R3: With bit 6 = 0 and bit 2 = 0, the positive channel is {addr, odd}, the negative channel is {addr, ~odd}, and the ground flag is 0.
- R4: With bit 6 = 1 and bit 2 = 0, the positive channel is {addr, odd}, the ground flag is 1, and the negative channel reads 0.
- R5: With bit 6 = 1 and bit 2 = 1, the positive channel is {addr, odd} and the negative channel is 7 with the ground flag 0. A word that would make channel 7 positive is rejected: the error flag rises and all selection outputs stay unchanged.
- R6: A word with bit 6 = 0 and bit 2 = 1 is rejected. The error flag is set and the selection, mode and sleep outputs keep their values. The next accepted word clears the error flag.
- R7: A frame with fewer than 7 bits leaves every decoded output and the error flag unchanged. Bits after the seventh in a frame are ignored.
- R8: `sdo_oe` is 0 one clock after chip-select is high and 1 one clock after it is low.
- R9: The result leaves MSB first, RES_W bits wide. Each bit is held from one serial-clock falling edge to the next. Zeros follow the last bit.
- R10: In unipolar mode the word sent equals the core code. In bipolar mode the MSB of the core code is inverted (two's complement). The mode used is the one in force when the done strobe arrives.
- R11: A done strobe while the frame is active puts the new MSB on `sdo` on the next clock. Every frame starts again from the MSB of the last latched result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial shift clock (synchronous sample) |
| cs_conv | input | 1 | Frame / conversion start, low = frame active |
| sdi | input | 1 | Serial setup word input |
| result_i | input | RES_W | Raw offset-binary code from converter core |
| eoc_i | input | 1 | One-cycle conversion-done strobe |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output driver enable for sdo |
| pos_ch | output | 3 | Positive input channel |
| neg_ch | output | 3 | Negative input channel |
| neg_is_gnd | output | 1 | Negative input is ground |
| unipolar | output | 1 | 1 = unipolar, straight binary |
| sleep_req | output | 1 | Sleep request |
| cfg_err | output | 1 | Last complete word was rejected |

## Verification
The bench goes after three kinds of error. The first is a rejected word, either a pair with the common bit set or channel 7 against itself. A faulty design would move the multiplexer or leave the error flag clear. The second is a frame cut short after five bits, which a careless counter would decode from stale shift contents, and a frame with extra clocks, which would shift the decoded fields. The third is the result path. The bench checks the bipolar MSB inversion, which a wrong formatter drops or applies in unipolar mode. It checks a done strobe in mid-frame, which must show the new MSB at once rather than wait for the next frame. It checks a repeated read, which must start over from the MSB instead of sending zeros.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    localparam int CFG_W = 7;

    typedef struct packed {
        logic [2:0] pos;
        logic [2:0] neg;
        logic       neg_gnd;
        logic       uni;
        logic       slp;
    } sel_t;

    typedef struct packed {
        logic ok;
        sel_t sel;
    } dec_t;

    localparam sel_t SEL_RST = '{pos: 3'd0, neg: 3'd1, neg_gnd: 1'b0, uni: 1'b0, slp: 1'b0};

    // Field positions: [6] single-ended, [5] odd, [4:3] address, [2] common, [1] unipolar, [0] sleep
    function automatic dec_t decode_word(input logic [CFG_W-1:0] w);
        dec_t       r;
        logic [2:0] ch;
        ch          = {w[4:3], w[5]};
        r.ok        = 1'b1;
        r.sel.pos   = ch;
        r.sel.uni   = w[1];
        r.sel.slp   = w[0];
        r.sel.neg   = 3'd0;
        r.sel.neg_gnd = 1'b0;
        if (!w[6]) begin
            r.ok      = !w[2];
            r.sel.neg = {w[4:3], ~w[5]};
        end else if (!w[2]) begin
            r.sel.neg_gnd = 1'b1;
        end else begin
            r.ok      = (ch != 3'd7);
            r.sel.neg = 3'd7;
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_cfg_rx.sv
module adc_cfg_rx
    import adc_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_rise,
    input  logic cs_act,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic sdi,
    output sel_t sel_o,
    output logic err_o
);

    localparam int CNT_W = $clog2(CFG_W + 1);

    typedef struct packed {
        logic [CFG_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        sel_t             sel;
        logic             err;
    } rx_t;

    rx_t  q, d;
    dec_t dec;

    always_comb begin
        d   = q;
        dec = decode_word(q.sh);
        if (cs_fall) begin
            d.cnt = '0;
        end else if (sck_rise && cs_act && (q.cnt != CNT_W'(CFG_W))) begin
            d.sh  = {q.sh[CFG_W-2:0], sdi};
            d.cnt = q.cnt + 1'b1;
        end
        if (cs_rise && (q.cnt == CNT_W'(CFG_W))) begin
            if (dec.ok) begin
                d.sel = dec.sel;
                d.err = 1'b0;
            end else begin
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh  <= '0;
            q.cnt <= '0;
            q.sel <= SEL_RST;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sel_o = q.sel;
    assign err_o = q.err;

    p_hold_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(q.sel));
    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sel.neg_gnd && q.sel.neg != 3'd7) |->
            (q.sel.pos[2:1] == q.sel.neg[2:1] && q.sel.pos[0] != q.sel.neg[0]));
    p_gnd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.sel.neg_gnd |-> q.sel.neg == 3'd0);
    p_com_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sel.neg_gnd && q.sel.neg == 3'd7) |-> q.sel.pos != 3'd7);
    p_keep_on_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> $stable(q.sel));
    p_partial_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && q.cnt != CNT_W'(CFG_W)) |=> ($stable(q.sel) && $stable(q.err)));

endmodule

// File: rtl/adc_res_tx.sv
module adc_res_tx #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_fall,
    input  logic             cs_act,
    input  logic             cs_fall,
    input  logic             uni,
    input  logic [RES_W-1:0] result_i,
    input  logic             eoc_i,
    output logic             sdo
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [RES_W-1:0] sh;
    } tx_t;

    tx_t              q, d;
    logic [RES_W-1:0] fmt;

    always_comb begin
        d   = q;
        fmt = uni ? result_i : {~result_i[RES_W-1], result_i[RES_W-2:0]};
        if (eoc_i) begin
            d.res = fmt;
            d.sh  = fmt;
        end else if (cs_fall) begin
            d.sh = q.res;
        end else if (sck_fall && cs_act) begin
            d.sh = {q.sh[RES_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo = q.sh[RES_W-1];

    p_eoc_msb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_i |=> sdo == $past(result_i[RES_W-1] ^ !uni));
    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !eoc_i) |=> q.sh == $past(q.res));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoc_i && !cs_fall && !sck_fall) |=> $stable(sdo));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_conv,
    input  logic             sdi,
    input  logic [RES_W-1:0] result_i,
    input  logic             eoc_i,
    output logic             sdo,
    output logic             sdo_oe,
    output logic [2:0]       pos_ch,
    output logic [2:0]       neg_ch,
    output logic             neg_is_gnd,
    output logic             unipolar,
    output logic             sleep_req,
    output logic             cfg_err
);

    typedef struct packed {
        logic sck;
        logic cs;
    } lin_t;

    lin_t q, d;
    logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act;
    sel_t sel;

    always_comb begin
        d.sck    = sck;
        d.cs     = cs_conv;
        sck_rise = sck && !q.sck;
        sck_fall = !sck && q.sck;
        cs_fall  = !cs_conv && q.cs;
        cs_rise  = cs_conv && !q.cs;
        cs_act   = !cs_conv && !q.cs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck <= 1'b0;
            q.cs  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    adc_cfg_rx i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .cs_act   (cs_act),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sdi      (sdi),
        .sel_o    (sel),
        .err_o    (cfg_err)
    );

    adc_res_tx #(.RES_W(RES_W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_fall  (cs_fall),
        .uni      (sel.uni),
        .result_i (result_i),
        .eoc_i    (eoc_i),
        .sdo      (sdo)
    );

    assign sdo_oe     = !q.cs;
    assign pos_ch     = sel.pos;
    assign neg_ch     = sel.neg;
    assign neg_is_gnd = sel.neg_gnd;
    assign unipolar   = sel.uni;
    assign sleep_req  = sel.slp;

    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_conv |=> !sdo_oe);
    p_oe_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_conv |=> sdo_oe);

endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;

    localparam int RES_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sck = 1'b0;
    logic             cs_conv = 1'b1;
    logic             sdi = 1'b0;
    logic [RES_W-1:0] result_i = '0;
    logic             eoc_i = 1'b0;
    logic             sdo, sdo_oe, neg_is_gnd, unipolar, sleep_req, cfg_err;
    logic [2:0]       pos_ch, neg_ch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic exp_bits[$];
    string exp_tag = "R9";

    // reference model state
    logic [2:0]       m_pos = 3'd0, m_neg = 3'd1;
    logic             m_gnd = 1'b0, m_uni = 1'b0, m_slp = 1'b0, m_err = 1'b0;
    logic [RES_W-1:0] m_res = '0;

    always #4 clk = ~clk;

    adc_serial_port #(.RES_W(RES_W)) i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_conv(cs_conv), .sdi(sdi),
        .result_i(result_i), .eoc_i(eoc_i), .sdo(sdo), .sdo_oe(sdo_oe),
        .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_is_gnd(neg_is_gnd),
        .unipolar(unipolar), .sleep_req(sleep_req), .cfg_err(cfg_err)
    );

    function automatic logic [RES_W-1:0] fmt(input logic [RES_W-1:0] v, input logic u);
        return u ? v : (v ^ {1'b1, {(RES_W-1){1'b0}}});
    endfunction

    function automatic logic [6:0] mk(input logic sd, input logic odd, input logic [1:0] a,
                                      input logic com, input logic u, input logic s);
        return {sd, odd, a, com, u, s};
    endfunction

    task automatic model_apply(input logic [6:0] w);
        logic [2:0] ch;
        ch = {w[4:3], w[5]};
        if ((!w[6] && w[2]) || (w[6] && w[2] && ch == 3'd7)) begin
            m_err = 1'b1;
        end else begin
            m_err = 1'b0;
            m_pos = ch;
            m_uni = w[1];
            m_slp = w[0];
            if (!w[6]) begin m_neg = {w[4:3], ~w[5]}; m_gnd = 1'b0; end
            else if (!w[2]) begin m_neg = 3'd0; m_gnd = 1'b1; end
            else begin m_neg = 3'd7; m_gnd = 1'b0; end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_sel(input string tag);
        chk(tag, {22'd0, pos_ch, neg_ch, neg_is_gnd, unipolar, sleep_req, cfg_err},
                 {22'd0, m_pos, m_neg, m_gnd, m_uni, m_slp, m_err});
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_eoc(input logic [RES_W-1:0] v);
        result_i = v;
        eoc_i = 1'b1;
        clks(1);
        eoc_i = 1'b0;
        m_res = fmt(v, m_uni);
    endtask

    // driver: one framed transfer; pushes the expected serial bits for the monitor
    task automatic frame(input logic [6:0] w, input int nsck, input bit mid_eoc,
                         input logic [RES_W-1:0] ev, input string tag);
        clks(1);
        cs_conv = 1'b0;
        clks(4);
        chk("R8 oe on", {31'd0, sdo_oe}, 32'd1);
        if (mid_eoc) begin
            pulse_eoc(ev);
            clks(1);
            chk("R11 msb at eoc", {31'd0, sdo}, {31'd0, m_res[RES_W-1]});
        end
        exp_tag = tag;
        for (int i = 0; i < nsck; i++)
            exp_bits.push_back(i < RES_W ? m_res[RES_W-1-i] : 1'b0);
        for (int i = 0; i < nsck; i++) begin
            sdi = (i < 7) ? w[6-i] : ~w[0];
            clks(2);
            sck = 1'b1;
            clks(4);
            sck = 1'b0;
            clks(2);
        end
        chk_sel("R2 hold in frame");
        chk("R9 all bits consumed", exp_bits.size(), 32'd0);
        cs_conv = 1'b1;
        clks(4);
        chk("R8 oe off", {31'd0, sdo_oe}, 32'd0);
        if (nsck >= 7) model_apply(w);
    endtask

    // monitor: compare sdo at each serial-clock rising edge
    always @(posedge sck) begin
        if (exp_bits.size() > 0) begin
            logic e;
            e = exp_bits.pop_front();
            chk(exp_tag, {31'd0, sdo}, {31'd0, e});
        end
    end

    initial begin
        clks(3);
        rst_n = 1'b1;
        clks(2);
        chk_sel("R1 reset selection");
        chk("R1 reset oe", {31'd0, sdo_oe}, 32'd0);

        // bipolar result, then differential swapped pair 5/4, unipolar
        pulse_eoc(16'hA5C3);
        frame(mk(1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0), 16, 1'b0, '0, "R10 bipolar word");
        chk_sel("R3 pair swapped");

        // unipolar result, single-ended ch6 vs ground, sleep
        pulse_eoc(16'hA5C3);
        frame(mk(1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1), 16, 1'b0, '0, "R10 unipolar word");
        chk_sel("R4 ground reference");

        // repeated read starts at MSB again
        frame(mk(1'b1, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0), 16, 1'b0, '0, "R11 reread");
        chk_sel("R5 common reference ch3");

        // differential with common bit: rejected
        frame(mk(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1), 7, 1'b0, '0, "R9 short read");
        chk_sel("R6 reject pair+common");

        // channel 7 against common: rejected
        frame(mk(1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0), 7, 1'b0, '0, "R9 short read");
        chk_sel("R5 reject ch7 common");

        // five-bit frame is discarded
        frame(mk(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1), 5, 1'b0, '0, "R9 partial read");
        chk_sel("R7 partial discarded");

        // ten clocks: extra bits ignored, error cleared
        frame(mk(1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0), 10, 1'b0, '0, "R9 read");
        chk_sel("R7 extra bits ignored R6 clear");

        // result arrives in mid-frame; 20 clocks check trailing zeros
        frame(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0), 20, 1'b1, 16'h8001, "R9 trailing zeros");
        chk_sel("R3 pair 0/1");

        // bipolar formatting of a mid-frame result
        frame(mk(1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0), 16, 1'b1, 16'h1234, "R10 bipolar mid");
        chk_sel("R4 ch5 ground");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule